// File: doc/BRIEF.md
# Sector-aware flash write sequencer

This block programs a run of 32-bit words into a serial flash device. It does not drive the flash pins. It works through an indirect access port made of two registers. The data register holds the word to be written. The address register carries a busy/complete flag. The host gives a starting word address, a word count and a start pulse, then feeds the words on a valid/ready stream.

A run starts by reading the device identification word, which sets the sector geometry. The block then clears write protection and programs the words in ascending address order. An erase command goes out ahead of every word that opens a sector. Each port access waits for the flag with a cycle-count timeout. A timed-out erase or program ends the run with an error. A flash-enable output covers the whole run.

Top module: `fsq_flash_writer`

## Requirements
- R1: While reset is held, and after it, busy, done, error, flash_en, wr_ready and both port strobes are low.
- R2: Each run starts with one read: an address write of data-space word 0xD03AB with the written flag 0 (acc_flag_wr low), before any port write. The read completes when acc_flag goes high. acc_rdata[7:0] is the manufacturer code and acc_rdata[15:8] the device code.
- R3: Manufacturer 0xBF selects in-sector offset mask 0x1FFF and sector mask 0x3E000. Its erase command goes to configuration address 0x352 when the device code is 0x80, and to 0x3D8 for any other device code.
- R4: Any other manufacturer selects offset mask 0x3FFF, sector mask 0x3C000 and erase address 0x3D8. If the identification read times out, the block uses these values too.
- R5: The first port write of a run puts 0 into configuration address 0x101 (acc_cfg high). A timeout on this write does not end the run.
- R6: Before programming a word whose address ANDed with the offset mask is zero, the block sends one erase write to the configuration erase address.
- R7: Let v = (word address AND sector mask) shifted left by 2. The erase data has bits 23:16 of v in bits 7:0, bits 15:8 of v in bits 15:8, bits 7:0 of v in bits 23:16, and zero in bits 31:24.
- R8: Every port write loads the data register (acc_data_we) in the cycle just before its address write. The address write has the flag set (acc_flag_wr high), and the block then waits for acc_flag to go low. The two strobes are never high together.
- R9: Words are taken from the stream one per program write, only while wr_ready is high, and written in stream order to consecutive data-space addresses from start_addr. wr_ready is high only during a run.
- R10: A wait longer than TMO_CYCLES cycles on an erase or program write stops the run. No further words are taken, and error rises together with done. error then holds until the next start.
- R11: flash_en is high for the whole run and drops in the same cycle as the single-cycle done pulse. A start pulse while busy is ignored.
- R12: A word count of zero gives only the identification read and the protection write, then done with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken when idle) |
| start_addr | input | PORT_AW | First word address |
| word_count | input | CNT_W | Number of words to program |
| wr_valid | input | 1 | Stream word available |
| wr_data | input | 32 | Stream word |
| wr_ready | output | 1 | Stream word taken when valid and ready |
| acc_addr_we | output | 1 | Address register write strobe |
| acc_addr | output | PORT_AW | Address written to the port |
| acc_cfg | output | 1 | 1 = configuration space, 0 = data space |
| acc_flag_wr | output | 1 | Flag value written with the address (1 = write, 0 = read) |
| acc_data_we | output | 1 | Data register write strobe |
| acc_wdata | output | 32 | Data register value |
| acc_flag | input | 1 | Current port flag |
| acc_rdata | input | 16 | Low half of the port data register |
| flash_en | output | 1 | Flash write enable for the run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Last run ended on a timeout |

## Verification
A wrong captured identification code would not show as an error. It shows as an erase missing, extra or sent to the other configuration address, seen at the first sector-opening word after the identification read. An address or count register that is off by one puts a program write at the wrong address, or changes the number of stream words taken, and the port log shows this within the same run. A timer that is too short or too long shows up as a false error or a late done, and only on a stalled access. The bench therefore stalls single accesses at chosen positions in the write order.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_ID_ADDR, S_ID_WAIT, S_WP_DATA, S_WP_ADDR, S_WP_WAIT,
      S_CHECK, S_ER_DATA, S_ER_ADDR, S_ER_WAIT, S_FETCH, S_PG_ADDR, S_PG_WAIT
   } fsq_state_e;

   // fixed port addresses (20 significant bits)
   localparam logic [19:0] ID_WORD_ADDR  = 20'hD03AB;
   localparam logic [19:0] UNPROT_CFG    = 20'h00101;
   localparam logic [19:0] ERASE_CFG_STD = 20'h003D8;
   localparam logic [19:0] ERASE_CFG_ALT = 20'h00352;

   // geometry selection codes
   localparam logic [7:0]  MFR_SMALL_SECT = 8'hBF;
   localparam logic [7:0]  DEV_ALT_ERASE  = 8'h80;

   // identification value assumed when the read never completes
   localparam logic [15:0] ID_FALLBACK    = 16'hDEAD;

endpackage

// File: rtl/fsq_geometry.sv
module fsq_geometry #(
   parameter int AW = 20
) (
   input  logic [7:0]    mfr,
   input  logic [7:0]    dev,
   output logic [AW-1:0] off_mask,
   output logic [AW-1:0] sec_mask,
   output logic [AW-1:0] erase_addr
);
   import fsq_pkg::*;

   logic small_sect;

   assign small_sect = (mfr == MFR_SMALL_SECT);

   always_comb begin
      if (small_sect) begin
         off_mask   = AW'(20'h01FFF);
         sec_mask   = AW'(20'h3E000);
         erase_addr = (dev == DEV_ALT_ERASE) ? AW'(ERASE_CFG_ALT) : AW'(ERASE_CFG_STD);
      end else begin
         off_mask   = AW'(20'h03FFF);
         sec_mask   = AW'(20'h3C000);
         erase_addr = AW'(ERASE_CFG_STD);
      end
   end
endmodule

// File: rtl/fsq_erase_arg.sv
module fsq_erase_arg #(
   parameter int AW = 20
) (
   input  logic [AW-1:0] word_addr,
   input  logic [AW-1:0] sec_mask,
   output logic [31:0]   arg
);
   localparam int LANES = 3;

   logic [AW+1:0]      shifted;
   logic [8*LANES-1:0] v;

   assign shifted = {word_addr & sec_mask, 2'b00};
   assign v       = (8*LANES)'(shifted);

   // byte lane k of v lands in lane LANES-1-k of the argument
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign arg[8*(LANES-1-k) +: 8] = v[8*k +: 8];
   end
   assign arg[31:8*LANES] = '0;
endmodule

// File: rtl/fsq_wait_timer.sv
module fsq_wait_timer #(
   parameter int TMO_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int TW = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;

   logic [TW-1:0] cnt;

   assign expired = run && (cnt == TW'(TMO_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!run)          cnt <= '0;
      else if (!expired)      cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/fsq_flash_writer.sv
module fsq_flash_writer #(
   parameter int PORT_AW    = 20,
   parameter int CNT_W      = 16,
   parameter int TMO_CYCLES = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [PORT_AW-1:0] start_addr,
   input  logic [CNT_W-1:0]   word_count,
   input  logic               wr_valid,
   input  logic [31:0]        wr_data,
   output logic               wr_ready,
   output logic               acc_addr_we,
   output logic [PORT_AW-1:0] acc_addr,
   output logic               acc_cfg,
   output logic               acc_flag_wr,
   output logic               acc_data_we,
   output logic [31:0]        acc_wdata,
   input  logic               acc_flag,
   input  logic [15:0]        acc_rdata,
   output logic               flash_en,
   output logic               busy,
   output logic               done,
   output logic               error
);
   import fsq_pkg::*;

   if (PORT_AW < 20) begin : g_bad_aw
      $error("PORT_AW must hold the identification address");
   end
   if (TMO_CYCLES < 2) begin : g_bad_tmo
      $error("TMO_CYCLES must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   fsq_state_e         state;
   logic [PORT_AW-1:0] cur_addr;
   logic [CNT_W-1:0]   remain;
   logic [7:0]         mfr, dev;
   logic [PORT_AW-1:0] off_mask, sec_mask, erase_addr;
   logic [31:0]        erase_arg;
   logic               waiting, expired, opens_sector;

   fsq_geometry #(.AW(PORT_AW)) u_geom (
      .mfr(mfr), .dev(dev),
      .off_mask(off_mask), .sec_mask(sec_mask), .erase_addr(erase_addr)
   );

   fsq_erase_arg #(.AW(PORT_AW)) u_arg (
      .word_addr(cur_addr), .sec_mask(sec_mask), .arg(erase_arg)
   );

   assign waiting = (state == S_ID_WAIT) || (state == S_WP_WAIT) ||
                    (state == S_ER_WAIT) || (state == S_PG_WAIT);

   fsq_wait_timer #(.TMO_CYCLES(TMO_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .run(waiting), .expired(expired)
   );

   assign opens_sector = ((cur_addr & off_mask) == '0);
   assign busy         = (state != S_IDLE);
   assign wr_ready     = (state == S_FETCH);

   // port strobes and values decoded from the state
   always_comb begin
      acc_addr_we = 1'b0;
      acc_addr    = '0;
      acc_cfg     = 1'b0;
      acc_flag_wr = 1'b1;
      acc_data_we = 1'b0;
      acc_wdata   = '0;
      unique case (state)
         S_ID_ADDR: begin
            acc_addr_we = 1'b1;
            acc_addr    = PORT_AW'(ID_WORD_ADDR);
            acc_flag_wr = 1'b0;
         end
         S_WP_DATA: acc_data_we = 1'b1;
         S_WP_ADDR: begin
            acc_addr_we = 1'b1;
            acc_addr    = PORT_AW'(UNPROT_CFG);
            acc_cfg     = 1'b1;
         end
         S_ER_DATA: begin
            acc_data_we = 1'b1;
            acc_wdata   = erase_arg;
         end
         S_ER_ADDR: begin
            acc_addr_we = 1'b1;
            acc_addr    = erase_addr;
            acc_cfg     = 1'b1;
         end
         S_FETCH: begin
            acc_data_we = wr_valid;
            acc_wdata   = wr_data;
         end
         S_PG_ADDR: begin
            acc_addr_we = 1'b1;
            acc_addr    = cur_addr;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         cur_addr <= '0;
         remain   <= '0;
         mfr      <= '0;
         dev      <= '0;
         flash_en <= 1'b0;
         done     <= 1'b0;
         error    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            S_IDLE: if (start) begin
               cur_addr <= start_addr;
               remain   <= word_count;
               error    <= 1'b0;
               flash_en <= 1'b1;
               state    <= S_ID_ADDR;
            end
            S_ID_ADDR: state <= S_ID_WAIT;
            S_ID_WAIT: if (acc_flag) begin
               mfr   <= acc_rdata[7:0];
               dev   <= acc_rdata[15:8];
               state <= S_WP_DATA;
            end else if (expired) begin
               mfr   <= ID_FALLBACK[7:0];
               dev   <= ID_FALLBACK[15:8];
               state <= S_WP_DATA;
            end
            S_WP_DATA: state <= S_WP_ADDR;
            S_WP_ADDR: state <= S_WP_WAIT;
            S_WP_WAIT: if (!acc_flag || expired) state <= S_CHECK;
            S_CHECK: begin
               if (remain == '0) begin
                  state    <= S_IDLE;
                  done     <= 1'b1;
                  flash_en <= 1'b0;
               end else if (opens_sector) begin
                  state <= S_ER_DATA;
               end else begin
                  state <= S_FETCH;
               end
            end
            S_ER_DATA: state <= S_ER_ADDR;
            S_ER_ADDR: state <= S_ER_WAIT;
            S_FETCH:   if (wr_valid) state <= S_PG_ADDR;
            S_PG_ADDR: state <= S_PG_WAIT;
            S_ER_WAIT, S_PG_WAIT: begin
               if (!acc_flag) begin
                  if (state == S_PG_WAIT) begin
                     cur_addr <= cur_addr + 1'b1;
                     remain   <= remain - 1'b1;
                     state    <= S_CHECK;
                  end else begin
                     state <= S_FETCH;
                  end
               end else if (expired) begin
                  state    <= S_IDLE;
                  done     <= 1'b1;
                  error    <= 1'b1;
                  flash_en <= 1'b0;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fsq_flash_writer_chk.sv
module fsq_flash_writer_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic error,
   input logic flash_en,
   input logic wr_ready,
   input logic acc_addr_we,
   input logic acc_flag_wr,
   input logic acc_data_we
);
   AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(acc_addr_we || acc_data_we));                          // R11
   AST_EN_COVERS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> flash_en);                                                // R11
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                   // R11
   AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !flash_en));                                    // R11
   AST_DATA_BEFORE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_addr_we && acc_flag_wr) |-> $past(acc_data_we));              // R8
   AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_addr_we && acc_data_we));                                    // R8
   AST_READY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready |-> busy);                                                // R9
   AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error) |-> done);                                            // R10
   AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(error));                             // R10
endmodule

bind fsq_flash_writer fsq_flash_writer_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .error(error), .flash_en(flash_en), .wr_ready(wr_ready),
   .acc_addr_we(acc_addr_we), .acc_flag_wr(acc_flag_wr), .acc_data_we(acc_data_we)
);

// File: tb/sim_fsq_flash_writer.sv
module sim_fsq_flash_writer;
   localparam int CLK_PERIOD = 10;
   localparam int AW  = 20;
   localparam int CW  = 16;
   localparam int TMO = 16;
   localparam int LAT = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [CW-1:0] word_count = '0;
   logic wr_valid, wr_ready;
   logic [31:0] wr_data;
   logic acc_addr_we, acc_cfg, acc_flag_wr, acc_data_we, flash_en, busy, done, error;
   logic [AW-1:0] acc_addr;
   logic [31:0] acc_wdata;
   logic acc_flag = 1'b0;
   logic [15:0] acc_rdata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fsq_flash_writer #(.PORT_AW(AW), .CNT_W(CW), .TMO_CYCLES(TMO)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .word_count(word_count), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ready(wr_ready), .acc_addr_we(acc_addr_we), .acc_addr(acc_addr),
      .acc_cfg(acc_cfg), .acc_flag_wr(acc_flag_wr), .acc_data_we(acc_data_we),
      .acc_wdata(acc_wdata), .acc_flag(acc_flag), .acc_rdata(acc_rdata),
      .flash_en(flash_en), .busy(busy), .done(done), .error(error)
   );

   // ---------------- port model ----------------
   logic [7:0] id_mfr = 8'h00, id_dev = 8'h00;
   logic       id_hang = 1'b0, stall_en = 1'b0;
   int         hang_abs = -1;
   int         log_n = 0, sidx = 0, sbase = 0, rd_cnt = 0, rd_at = 0;
   logic [31:0] cyc = '0;
   logic        lg_cfg  [256];
   logic [AW-1:0] lg_addr [256];
   logic [31:0] lg_data [256];
   logic [AW-1:0] rd_addr = '0;
   logic        rd_cfg = 1'b0, rmode = 1'b0, stuck = 1'b0;
   logic [31:0] dreg = '0;
   int          lat_cnt = 0;

   assign wr_valid = stall_en ? cyc[0] : 1'b1;
   assign wr_data  = 32'hC0DE0000 + 32'(sidx - sbase);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (acc_data_we) dreg <= acc_wdata;
      if (wr_valid && wr_ready) sidx <= sidx + 1;
      if (acc_addr_we) begin
         lat_cnt <= LAT;
         rmode   <= !acc_flag_wr;
         if (acc_flag_wr) begin
            lg_cfg[log_n]  <= acc_cfg;
            lg_addr[log_n] <= acc_addr;
            lg_data[log_n] <= dreg;
            log_n    <= log_n + 1;
            acc_flag <= 1'b1;
            stuck    <= (log_n == hang_abs);
         end else begin
            rd_cnt    <= rd_cnt + 1;
            rd_addr   <= acc_addr;
            rd_cfg    <= acc_cfg;
            rd_at     <= log_n;
            acc_flag  <= 1'b0;
            acc_rdata <= {id_dev, id_mfr};
            stuck     <= id_hang;
         end
      end else if (!stuck && lat_cnt != 0) begin
         lat_cnt <= lat_cnt - 1;
         if (lat_cnt == 1) acc_flag <= rmode;
      end
   end

   // ---------------- checking ----------------
   int n_checks = 0, n_errors = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic [7:0]  mfr;
      logic [7:0]  dev;
      logic [19:0] base;
      logic [7:0]  cnt;
      logic [7:0]  hang;
      logic        idh;
      logic [3:0]  n_er;
      logic [31:0] arg;
      logic [19:0] ecfg;
      logic        err;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VT [NV] = '{
      '{8'hBF, 8'h80, 20'h01FFE, 8'd4, 8'hFF, 1'b0, 4'd1, 32'h00008000, 20'h352, 1'b0}, // R3 alt erase
      '{8'hBF, 8'h25, 20'h05FFF, 8'd3, 8'hFF, 1'b0, 4'd1, 32'h00008001, 20'h3D8, 1'b0}, // R3 std erase
      '{8'h13, 8'h14, 20'h07FFF, 8'd2, 8'hFF, 1'b0, 4'd1, 32'h00000002, 20'h3D8, 1'b0}, // R4
      '{8'h20, 8'h00, 20'h0C000, 8'd1, 8'hFF, 1'b0, 4'd1, 32'h00000003, 20'h3D8, 1'b0}, // R4 R7
      '{8'hBF, 8'h80, 20'h00000, 8'd3, 8'hFF, 1'b0, 4'd1, 32'h00000000, 20'h352, 1'b0}, // R6 at 0
      '{8'hBF, 8'h80, 20'h01000, 8'd0, 8'hFF, 1'b0, 4'd0, 32'h00000000, 20'h000, 1'b0}, // R12
      '{8'h13, 8'h00, 20'h04000, 8'd3, 8'd1,  1'b0, 4'd1, 32'h00000001, 20'h3D8, 1'b1}, // R10 erase hang
      '{8'hBF, 8'h00, 20'h03FFF, 8'd4, 8'd3,  1'b0, 4'd1, 32'h00000001, 20'h3D8, 1'b1}, // R10 program hang
      '{8'hBF, 8'h80, 20'h02000, 8'd2, 8'hFF, 1'b1, 4'd0, 32'h00000000, 20'h000, 1'b0}, // R4 id timeout
      '{8'hBF, 8'h80, 20'h02000, 8'd2, 8'hFF, 1'b0, 4'd1, 32'h00008000, 20'h352, 1'b0}, // R3
      '{8'h13, 8'h00, 20'h00100, 8'd1, 8'd0,  1'b0, 4'd0, 32'h00000000, 20'h000, 1'b0}  // R5 hang ignored
   };

   task automatic run_vec(input vec_t v, input logic stall);
      int lb, rb, n, prog, n_er, got_er, first_er, k;
      logic eerr, seq_ok;
      logic [7:0] m;
      logic [AW-1:0] offm, secm, ecfg, a;
      logic [23:0] vv;
      logic        e_cfg [64];
      logic [AW-1:0] e_addr [64];
      logic [31:0] e_data [64];
      int done_seen;

      id_mfr = v.mfr; id_dev = v.dev; id_hang = v.idh; stall_en = stall;
      lb = log_n; rb = rd_cnt; sbase = sidx;
      hang_abs = (v.hang == 8'hFF) ? -1 : lb + int'(v.hang);

      @(negedge clk);
      start = 1'b1; start_addr = v.base; word_count = CW'(v.cnt);
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      if (busy) begin                       // R11: start while busy ignored
         start = 1'b1; start_addr = 20'h12345; word_count = 16'd9;
         @(negedge clk);
         start = 1'b0;
      end
      done_seen = 0;
      for (int t = 0; t < 4000; t++) begin
         if (done) begin done_seen = 1; break; end
         @(negedge clk);
      end
      chk("R11 done seen", 64'(done_seen), 64'd1);
      chk("R11 flash_en low at done", {62'd0, flash_en, busy}, 64'd0);
      chk("R10 error flag", 64'(error), 64'(v.err));
      @(negedge clk);
      chk("R11 done one cycle", 64'(done), 64'd0);

      // reference sequence from the requirements
      m = v.idh ? 8'hAD : v.mfr;
      if (m == 8'hBF) begin
         offm = 20'h01FFF; secm = 20'h3E000;
         ecfg = (v.dev == 8'h80 && !v.idh) ? 20'h352 : 20'h3D8;
      end else begin
         offm = 20'h03FFF; secm = 20'h3C000; ecfg = 20'h3D8;
      end
      n = 0; prog = 0; eerr = 1'b0; n_er = 0;
      e_cfg[0] = 1'b1; e_addr[0] = 20'h101; e_data[0] = 32'h0; n = 1;
      a = v.base;
      for (int i = 0; i < int'(v.cnt); i++) begin
         if ((a & offm) == '0) begin
            vv = 24'({(a & secm), 2'b00});
            e_cfg[n] = 1'b1; e_addr[n] = ecfg;
            e_data[n] = {8'h00, vv[7:0], vv[15:8], vv[23:16]};
            n++; n_er++;
            if (n - 1 == int'(v.hang)) begin eerr = 1'b1; break; end
         end
         e_cfg[n] = 1'b0; e_addr[n] = a; e_data[n] = 32'hC0DE0000 + 32'(i);
         n++; prog++;
         if (n - 1 == int'(v.hang)) begin eerr = 1'b1; break; end
         a = a + 1'b1;
      end

      chk("R10 error vs model", 64'(error), 64'(eerr));
      chk("R9 write count", 64'(log_n - lb), 64'(n));
      chk("R5 protect write first", {lg_cfg[lb], 11'd0, lg_addr[lb], lg_data[lb]},
          {1'b1, 11'd0, 20'h00101, 32'h0});
      seq_ok = 1'b1;
      for (int i = 0; i < n && i < 64; i++) begin
         k = lb + i;
         if (lg_cfg[k] !== e_cfg[i] || lg_addr[k] !== e_addr[i] || lg_data[k] !== e_data[i]) begin
            if (seq_ok)
               $display("FAIL R8 R9 write %0d actual=%0b/%0h/%0h expected=%0b/%0h/%0h", i,
                        lg_cfg[k], lg_addr[k], lg_data[k], e_cfg[i], e_addr[i], e_data[i]);
            seq_ok = 1'b0;
         end
      end
      n_checks++;
      if (!seq_ok) n_errors++;
      chk("R9 words consumed", 64'(sidx - sbase), 64'(prog));

      got_er = 0; first_er = -1;
      for (int i = lb + 1; i < log_n; i++)
         if (lg_cfg[i]) begin
            got_er++;
            if (first_er < 0) first_er = i;
         end
      chk("R6 erase count", 64'(got_er), 64'(v.n_er));
      chk("R6 erase count vs model", 64'(got_er), 64'(n_er));
      if (first_er >= 0) begin
         chk("R7 erase argument", 64'(lg_data[first_er]), 64'(v.arg));
         chk((v.mfr == 8'hBF && !v.idh) ? "R3 erase address" : "R4 erase address",
             64'(lg_addr[first_er]), 64'(v.ecfg));
      end
      chk("R2 single id read", 64'(rd_cnt - rb), 64'd1);
      chk("R2 id read address", {43'd0, rd_cfg, rd_addr}, {43'd0, 1'b0, 20'hD03AB});
      chk("R2 id read before writes", 64'(rd_at), 64'(lb));
      if (v.cnt == 8'd0) chk("R12 empty run", {62'd0, error, 1'(log_n - lb == 1)}, 64'd1);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", {56'd0, busy, done, error, flash_en, wr_ready, acc_addr_we, acc_data_we, 1'b0}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", {57'd0, busy, done, error, flash_en, wr_ready, acc_addr_we, acc_data_we}, 64'd0);

      for (int i = 0; i < NV; i++) run_vec(VT[i], 1'(i % 2));

      // reset in the middle of a run
      @(negedge clk);
      start = 1'b1; start_addr = 20'h01FFE; word_count = 16'd4;
      id_mfr = 8'hBF; id_dev = 8'h80; id_hang = 1'b0; hang_abs = -1;
      @(negedge clk);
      start = 1'b0;
      repeat (8) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset mid run", {57'd0, busy, done, error, flash_en, wr_ready, acc_addr_we, acc_data_we}, 64'd0);
      rst_n = 1'b1;
      repeat (2 * LAT) @(negedge clk);
      run_vec(VT[9], 1'b0);                // R3 recovery after reset

      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule